// File: doc/BRIEF.md
# Sub-Second Real-Time Counter with Split Alarms

This block keeps time with two linked counters on a slow 32768 Hz tick clock. A 15-bit fraction counter advances once per tick. When it passes its top value it arms a carry, and a seconds counter takes that carry on the following tick. Each counter has its own alarm. An alarm fires either when its counter steps onto a programmed value or on every step of that counter. Alarm events set sticky status bits, and the interrupt line is driven from those bits through per-alarm enables.

Software talks to the block through a simple register port on a fast bus clock. Writes are posted. The write is captured in the fast domain, carried across to the tick domain by a toggle handshake, and applied there. Busy flags stay raised until the new value can be read back. Reads come from a shadow copy that the tick domain refreshes once per tick, so a read never sees a counter halfway through an update.

Top module: `rtc_subsec_timer`

## Requirements
- R1: The fraction counter (address 3, bits [14:0]) rises by one per tick while it runs and goes from 0x7FFF to 0.
- R2: The tick that wraps the fraction counter arms a carry. The seconds counter (address 4) takes the carry on the next tick in which its start bit is set, so for at least one tick the fraction reads 0 while the seconds keep their old value. A carry taken while the seconds are stopped waits until they run again.
- R3: Control (address 0) bit 0 starts the fraction counter and bit 1 starts the seconds counter. Each counter holds its value while its bit is clear, whatever the other bit is.
- R4: With bit 31 of an alarm register clear (fraction alarm at address 5, seconds alarm at address 6, value in the low bits), the status bit is set on the step that brings the counter onto the alarm value. Status (address 1) bit 0 is the fraction alarm and bit 1 is the seconds alarm.
- R5: With bit 31 of an alarm register set, its status bit is set on every step of that counter.
- R6: Status bits are sticky. Writing 1 to bit 0 or bit 1 of the clear register (address 2) clears only the matching status bit.
- R7: irq is high while (status bit 0 and control bit 2) or (status bit 1 and control bit 3). A status bit stays set when its enable is dropped.
- R8: Both counters and both alarms can be loaded by software and read back. Loading the seconds counter discards a pending carry.
- R9: Status bit 3 is high from the cycle after a write is accepted until the written value can be read. Status bit 2 is high over the same span, but only for control writes. A write offered while bit 3 is high is ignored.
- R10: Writing control with bit 4 set clears both counters and the pending carry. Bit 4 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-port clock |
| tick_clk | input | 1 | 32768 Hz counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data from the shadow copy, combinational on bus_addr |
| irq | output | 1 | Level interrupt |

## Verification
A write offered one bus cycle after a tick edge is accepted on the next bus edge. It is applied on the third tick edge after that and becomes readable about one tick later, when status bit 3 drops. The bench therefore issues every write aligned to a tick edge and polls bit 3 before each read. A counting run is a start write followed by a stop write exactly N tick edges later. Since both writes see the same latency, the counters step exactly N times, and the bench works out the expected fraction, seconds and alarm status from that N. The busy bits are sampled one bus cycle after acceptance. Every other result is read only after busy has cleared.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
   localparam logic [ADDR_W-1:0] A_ICLR = 3'd2;
   localparam logic [ADDR_W-1:0] A_FRAC = 3'd3;
   localparam logic [ADDR_W-1:0] A_SECS = 3'd4;
   localparam logic [ADDR_W-1:0] A_FALM = 3'd5;
   localparam logic [ADDR_W-1:0] A_SALM = 3'd6;

   // control bits: starts, then enables (fraction below seconds), then clear
   localparam int CB_FRUN = 0;
   localparam int CB_SRUN = 1;
   localparam int CB_FIE  = 2;
   localparam int CB_SIE  = 3;
   localparam int CB_CLR  = 4;

   // status bits
   localparam int SB_FHIT = 0;
   localparam int SB_SHIT = 1;
   localparam int SB_CBSY = 2;
   localparam int SB_ABSY = 3;
endpackage

// File: rtl/rtc_bit_sync.sv
module rtc_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else if (i == 0) chain_q[i] <= d;
            else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_post_wr.sv
module rtc_post_wr #(
   parameter int AW     = 3,
   parameter int DW     = 32,
   parameter int SYNC_N = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic          ack_tgl_i,
   input  logic          cap_stb_i,
   output logic          req_tgl_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o,
   output logic          busy_o
);
   logic ack_s;
   logic accept;

   rtc_bit_sync #(.STAGES(SYNC_N)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_tgl_i), .q(ack_s)
   );

   assign accept = wr_i && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl_o <= 1'b0;
         addr_o    <= '0;
         data_o    <= '0;
         busy_o    <= 1'b0;
      end else if (accept) begin
         req_tgl_o <= ~req_tgl_o;
         addr_o    <= addr_i;
         data_o    <= data_i;
         busy_o    <= 1'b1;
      end else if (busy_o && (ack_s == req_tgl_o) && cap_stb_i) begin
         // applied and a snapshot taken after it is being captured
         busy_o <= 1'b0;
      end
   end
endmodule

// File: rtl/rtc_snap_xfer.sv
module rtc_snap_xfer #(
   parameter int W      = 8,
   parameter int SYNC_N = 2
) (
   input  logic         src_clk,
   input  logic         dst_clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_d,
   output logic [W-1:0] dst_q,
   output logic         dst_stb
);
   logic [W-1:0] hold_q;
   logic         tgl_q;
   logic         tgl_s;
   logic         tgl_d;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         tgl_q  <= 1'b0;
      end else begin
         hold_q <= src_d;
         tgl_q  <= ~tgl_q;
      end
   end

   rtc_bit_sync #(.STAGES(SYNC_N)) u_tgl_sync (
      .clk(dst_clk), .rst_n(rst_n), .d(tgl_q), .q(tgl_s)
   );

   assign dst_stb = tgl_s ^ tgl_d;

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_d <= 1'b0;
         dst_q <= '0;
      end else begin
         tgl_d <= tgl_s;
         if (dst_stb) dst_q <= hold_q;
      end
   end
endmodule

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
   import rtc_pkg::*;
#(
   parameter int SUB_W  = 15,
   parameter int SEC_W  = 24,
   parameter int DW     = 32,
   parameter int SYNC_N = 2
) (
   input  logic              tick_clk,
   input  logic              rst_n,
   input  logic              req_tgl_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     data_i,
   output logic              ack_tgl_o,
   output logic              apply_o,
   output logic              pend_o,
   output logic [3:0]        ctrl_o,
   output logic [1:0]        stat_o,
   output logic [SUB_W-1:0]  frac_o,
   output logic [SEC_W-1:0]  secs_o,
   output logic              falm_md_o,
   output logic [SUB_W-1:0]  falm_o,
   output logic              salm_md_o,
   output logic [SEC_W-1:0]  salm_o
);
   localparam logic [SUB_W-1:0] FRAC_TOP = '1;

   logic req_s, req_d;
   logic w_ctrl, w_iclr, w_frac, w_secs, w_falm, w_salm, clr_go;
   logic frac_inc, secs_inc, wrap;
   logic [SUB_W-1:0] frac_nxt;
   logic [SEC_W-1:0] secs_nxt;
   logic f_hit, s_hit;

   rtc_bit_sync #(.STAGES(SYNC_N)) u_req_sync (
      .clk(tick_clk), .rst_n(rst_n), .d(req_tgl_i), .q(req_s)
   );

   assign apply_o = req_s ^ req_d;
   assign w_ctrl  = apply_o && (addr_i == A_CTRL);
   assign w_iclr  = apply_o && (addr_i == A_ICLR);
   assign w_frac  = apply_o && (addr_i == A_FRAC);
   assign w_secs  = apply_o && (addr_i == A_SECS);
   assign w_falm  = apply_o && (addr_i == A_FALM);
   assign w_salm  = apply_o && (addr_i == A_SALM);
   assign clr_go  = w_ctrl && data_i[CB_CLR];

   assign frac_inc = ctrl_o[CB_FRUN] && !w_frac && !clr_go;
   assign secs_inc = ctrl_o[CB_SRUN] && pend_o && !w_secs && !clr_go;
   assign frac_nxt = frac_o + 1'b1;
   assign secs_nxt = secs_o + 1'b1;
   assign wrap     = frac_inc && (frac_o == FRAC_TOP);
   assign f_hit    = frac_inc && (falm_md_o || (frac_nxt == falm_o));
   assign s_hit    = secs_inc && (salm_md_o || (secs_nxt == salm_o));

   always_ff @(posedge tick_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d     <= 1'b0;
         ack_tgl_o <= 1'b0;
         ctrl_o    <= '0;
         stat_o    <= '0;
         frac_o    <= '0;
         secs_o    <= '0;
         pend_o    <= 1'b0;
         falm_md_o <= 1'b0;
         falm_o    <= '0;
         salm_md_o <= 1'b0;
         salm_o    <= '0;
      end else begin
         req_d     <= req_s;
         ack_tgl_o <= req_d;
         if (w_ctrl) ctrl_o <= data_i[3:0];
         if (w_falm) begin
            falm_o    <= data_i[SUB_W-1:0];
            falm_md_o <= data_i[DW-1];
         end
         if (w_salm) begin
            salm_o    <= data_i[SEC_W-1:0];
            salm_md_o <= data_i[DW-1];
         end
         if (clr_go)        frac_o <= '0;
         else if (w_frac)   frac_o <= data_i[SUB_W-1:0];
         else if (frac_inc) frac_o <= frac_nxt;
         if (clr_go)        secs_o <= '0;
         else if (w_secs)   secs_o <= data_i[SEC_W-1:0];
         else if (secs_inc) secs_o <= secs_nxt;
         if (clr_go || w_secs) pend_o <= 1'b0;
         else                  pend_o <= wrap || (pend_o && !secs_inc);
         stat_o[SB_FHIT] <= f_hit || (stat_o[SB_FHIT] && !(w_iclr && data_i[0]));
         stat_o[SB_SHIT] <= s_hit || (stat_o[SB_SHIT] && !(w_iclr && data_i[1]));
      end
   end
endmodule

// File: rtl/rtc_subsec_timer.sv
module rtc_subsec_timer
   import rtc_pkg::*;
#(
   parameter int SUB_W  = 15,
   parameter int SEC_W  = 24,
   parameter int DW     = 32,
   parameter int SYNC_N = 2
) (
   input  logic              bus_clk,
   input  logic              tick_clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq
);
   localparam int SNAP_W = 4 + 2 + 2*SUB_W + 2*SEC_W + 2;

   if (SUB_W + 1 > DW || SEC_W + 1 > DW) begin : g_bad_width
      $error("counter width plus mode bit exceeds data width");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end

   logic              req_tgl, ack_tgl, cap_stb, busy, apply, pend;
   logic [ADDR_W-1:0] hold_addr;
   logic [DW-1:0]     hold_data;
   logic [3:0]        t_ctrl, r_ctrl;
   logic [1:0]        t_stat, r_stat;
   logic [SUB_W-1:0]  t_frac, r_frac, t_falm, r_falm;
   logic [SEC_W-1:0]  t_secs, r_secs, t_salm, r_salm;
   logic              t_fmd, r_fmd, t_smd, r_smd;
   logic [SNAP_W-1:0] snap_src, snap_dst;
   logic              ctrl_busy;

   rtc_post_wr #(.AW(ADDR_W), .DW(DW), .SYNC_N(SYNC_N)) u_post (
      .clk(bus_clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
      .data_i(bus_wdata), .ack_tgl_i(ack_tgl), .cap_stb_i(cap_stb),
      .req_tgl_o(req_tgl), .addr_o(hold_addr), .data_o(hold_data), .busy_o(busy)
   );

   rtc_tick_core #(.SUB_W(SUB_W), .SEC_W(SEC_W), .DW(DW), .SYNC_N(SYNC_N)) u_core (
      .tick_clk(tick_clk), .rst_n(rst_n), .req_tgl_i(req_tgl), .addr_i(hold_addr),
      .data_i(hold_data), .ack_tgl_o(ack_tgl), .apply_o(apply), .pend_o(pend),
      .ctrl_o(t_ctrl), .stat_o(t_stat), .frac_o(t_frac), .secs_o(t_secs),
      .falm_md_o(t_fmd), .falm_o(t_falm), .salm_md_o(t_smd), .salm_o(t_salm)
   );

   assign snap_src = {t_ctrl, t_stat, t_frac, t_secs, t_fmd, t_falm, t_smd, t_salm};

   rtc_snap_xfer #(.W(SNAP_W), .SYNC_N(SYNC_N)) u_snap (
      .src_clk(tick_clk), .dst_clk(bus_clk), .rst_n(rst_n),
      .src_d(snap_src), .dst_q(snap_dst), .dst_stb(cap_stb)
   );

   assign {r_ctrl, r_stat, r_frac, r_secs, r_fmd, r_falm, r_smd, r_salm} = snap_dst;
   assign ctrl_busy = busy && (hold_addr == A_CTRL);
   assign irq = (r_stat[SB_FHIT] && r_ctrl[CB_FIE]) || (r_stat[SB_SHIT] && r_ctrl[CB_SIE]);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: bus_rdata[3:0] = r_ctrl;
         A_STAT: bus_rdata[3:0] = {busy, ctrl_busy, r_stat};
         A_FRAC: bus_rdata[SUB_W-1:0] = r_frac;
         A_SECS: bus_rdata[SEC_W-1:0] = r_secs;
         A_FALM: begin
            bus_rdata[SUB_W-1:0] = r_falm;
            bus_rdata[DW-1]      = r_fmd;
         end
         A_SALM: begin
            bus_rdata[SEC_W-1:0] = r_salm;
            bus_rdata[DW-1]      = r_smd;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_subsec_timer_chk.sv
module rtc_subsec_timer_chk #(
   parameter int SUB_W = 15,
   parameter int SEC_W = 24,
   parameter int DW    = 32
) (
   input logic             bus_clk,
   input logic             tick_clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             busy,
   input logic [DW-1:0]    hold_data,
   input logic             apply,
   input logic             pend,
   input logic [3:0]       t_ctrl,
   input logic [1:0]       t_stat,
   input logic [SUB_W-1:0] t_frac,
   input logic [SEC_W-1:0] t_secs
);
   localparam logic [SUB_W-1:0] TOP = '1;

   // R1
   frac_wrap_chk: assert property (@(posedge tick_clk) disable iff (!rst_n)
      (t_ctrl[0] && !apply && t_frac == TOP) |=> (t_frac == '0));

   // R2
   secs_gap_chk: assert property (@(posedge tick_clk) disable iff (!rst_n)
      (t_ctrl[0] && t_ctrl[1] && !apply && !pend && t_frac == TOP) |=> (t_secs == $past(t_secs)));

   // R2
   secs_step_chk: assert property (@(posedge tick_clk) disable iff (!rst_n)
      (t_ctrl[1] && pend && !apply) |=> (t_secs == $past(t_secs) + 1'b1));

   // R3
   frac_hold_chk: assert property (@(posedge tick_clk) disable iff (!rst_n)
      (!t_ctrl[0] && !apply) |=> $stable(t_frac));

   // R6
   stat_sticky_chk: assert property (@(posedge tick_clk) disable iff (!rst_n)
      (t_stat != 2'b00 && !apply) |=> ((t_stat & $past(t_stat)) == $past(t_stat)));

   // R9
   busy_rise_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (bus_wr && !busy) |=> busy);

   // R9
   busy_ignore_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (bus_wr && busy) |=> $stable(hold_data));
endmodule

bind rtc_subsec_timer rtc_subsec_timer_chk #(.SUB_W(SUB_W), .SEC_W(SEC_W), .DW(DW)) u_chk (
   .bus_clk(bus_clk), .tick_clk(tick_clk), .rst_n(rst_n), .bus_wr(bus_wr),
   .busy(busy), .hold_data(hold_data), .apply(apply), .pend(pend),
   .t_ctrl(t_ctrl), .t_stat(t_stat), .t_frac(t_frac), .t_secs(t_secs)
);

// File: tb/tb_rtc_subsec_timer.sv
module tb_rtc_subsec_timer;
   localparam int SW = 24;
   localparam logic [2:0] A_CTRL = 0, A_STAT = 1, A_ICLR = 2, A_FRAC = 3,
                          A_SECS = 4, A_FALM = 5, A_SALM = 6;
   localparam logic [31:0] C_FR = 1, C_SR = 2, C_FIE = 4, C_SIE = 8, C_CLR = 16;
   localparam logic [31:0] MD = 32'h8000_0000;

   logic bus_clk = 0, tick_clk = 0, rst_n = 0, bus_wr = 0;
   logic [2:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic irq;
   int total = 0, bad = 0;

   rtc_subsec_timer dut (
      .bus_clk(bus_clk), .tick_clk(tick_clk), .rst_n(rst_n), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always #2.5 bus_clk = ~bus_clk;
   initial begin
      #1;
      forever #40 tick_clk = ~tick_clk;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge bus_clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      rd(A_STAT, s);
      while (s[3]) rd(A_STAT, s);
   endtask

   task automatic issue(input logic [2:0] a, input logic [31:0] d);
      @(posedge tick_clk);
      @(negedge bus_clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge bus_clk);
      bus_wr = 0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wait_idle();
      issue(a, d);
      wait_idle();
   endtask

   // start with run_bits, stop exactly n tick edges later, keeping keep_bits
   task automatic run(input int n, input logic [31:0] run_bits, input logic [31:0] keep_bits);
      wait_idle();
      issue(A_CTRL, run_bits | keep_bits);
      repeat (n - 1) @(posedge tick_clk);
      issue(A_CTRL, keep_bits);
      wait_idle();
   endtask

   function automatic logic [63:0] model(input logic [14:0] f, input logic [SW-1:0] s, input int n);
      logic p = 0;
      for (int i = 0; i < n; i++) begin
         if (p) begin s = s + 1'b1; p = 0; end
         if (f == 15'h7FFF) p = 1;
         f = f + 1'b1;
      end
      return {8'd0, s, 17'd0, f};
   endfunction

   initial begin
      repeat (150000) @(posedge bus_clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [63:0] m;
      void'($urandom(32'd1234));
      repeat (4) @(negedge bus_clk);
      rst_n = 1;
      repeat (4) @(posedge tick_clk);

      // reset state
      rd(A_CTRL, d); chk("R3 reset ctrl", d, 0);
      rd(A_STAT, d); chk("R9 reset stat", d, 0);
      rd(A_FRAC, d); chk("R1 reset frac", d, 0);
      rd(A_SECS, d); chk("R2 reset secs", d, 0);
      chk("R7 reset irq", {31'd0, irq}, 0);

      // R8 loads
      wr(A_FRAC, 32'h1234); wr(A_SECS, 32'hABCDE);
      wr(A_FALM, MD | 32'h55); wr(A_SALM, 32'h77);
      rd(A_FRAC, d); chk("R8 frac load", d, 32'h1234);
      rd(A_SECS, d); chk("R8 secs load", d, 32'hABCDE);
      rd(A_FALM, d); chk("R8 frac alarm", d, MD | 32'h55);
      rd(A_SALM, d); chk("R8 secs alarm", d, 32'h77);

      // R9 busy and ignored write
      wait_idle();
      issue(A_FRAC, 32'h100);
      rd(A_STAT, d); chk("R9 any busy", {28'd0, d[3:2]}, 32'h2);
      bus_wr = 1; bus_addr = A_FRAC; bus_wdata = 32'h200;
      @(negedge bus_clk); bus_wr = 0;
      wait_idle();
      rd(A_FRAC, d); chk("R9 write while busy ignored", d, 32'h100);
      issue(A_CTRL, 0);
      rd(A_STAT, d); chk("R9 ctrl busy", {28'd0, d[3:2]}, 32'h3);
      wait_idle();

      // R1 R2 wrap and carry gap
      wr(A_FALM, 32'h10); wr(A_FRAC, 32'h7FFA); wr(A_SECS, 5);
      run(6, C_FR | C_SR, 0);
      rd(A_FRAC, d); chk("R1 wrap to zero", d, 0);
      rd(A_SECS, d); chk("R2 secs waits one tick", d, 5);
      run(6, C_FR | C_SR, 0);
      rd(A_FRAC, d); chk("R1 frac after wrap", d, 6);
      rd(A_SECS, d); chk("R2 secs carried", d, 6);

      // R3 independent starts
      wr(A_FRAC, 32'h7FFA); wr(A_SECS, 20);
      run(6, C_FR, 0);
      rd(A_SECS, d); chk("R3 secs held while stopped", d, 20);
      run(6, C_SR, 0);
      rd(A_FRAC, d); chk("R3 frac held while stopped", d, 0);
      rd(A_SECS, d); chk("R2 held carry taken", d, 21);
      run(6, C_SR, 0);
      rd(A_SECS, d); chk("R3 no carry no step", d, 21);

      // R4 match alarm, R7 irq
      wr(A_ICLR, 3); wr(A_FRAC, 8);
      run(6, C_FR, C_FIE);
      rd(A_STAT, d); chk("R4 no hit before value", d, 0);
      chk("R7 irq low", {31'd0, irq}, 0);
      run(6, C_FR, C_FIE);
      rd(A_FRAC, d); chk("R4 frac passed alarm", d, 32'h14);
      rd(A_STAT, d); chk("R4 frac hit", d, 1);
      chk("R7 irq high", {31'd0, irq}, 1);

      // R6 R7 sticky, enable, independent clear
      wr(A_CTRL, 0);
      rd(A_STAT, d); chk("R7 status kept without enable", d, 1);
      chk("R7 irq masked", {31'd0, irq}, 0);
      wr(A_CTRL, C_FIE);
      chk("R7 irq re-enabled", {31'd0, irq}, 1);
      wr(A_ICLR, 2);
      rd(A_STAT, d); chk("R6 other bit untouched", d, 1);
      wr(A_ICLR, 1);
      rd(A_STAT, d); chk("R6 cleared", d, 0);
      chk("R6 irq after clear", {31'd0, irq}, 0);

      // R5 increment mode on seconds
      wr(A_SALM, MD); wr(A_FRAC, 32'h7FFA); wr(A_SECS, 9);
      run(6, C_FR | C_SR, C_SIE);
      rd(A_STAT, d); chk("R5 no secs step yet", d, 0);
      run(6, C_FR | C_SR, C_SIE);
      rd(A_STAT, d); chk("R5 secs step hit", d, 2);
      chk("R5 irq on secs", {31'd0, irq}, 1);
      rd(A_SECS, d); chk("R2 secs stepped", d, 10);
      wr(A_ICLR, 2);
      rd(A_STAT, d); chk("R6 secs cleared", d, 0);

      // R10 counter clear
      wr(A_CTRL, C_CLR);
      rd(A_FRAC, d); chk("R10 frac cleared", d, 0);
      rd(A_SECS, d); chk("R10 secs cleared", d, 0);
      rd(A_CTRL, d); chk("R10 clear bit reads 0", d, 0);

      // random loads and runs against the model
      wr(A_SALM, 0);
      for (int it = 0; it < 10; it++) begin
         logic [14:0] f0;
         logic [SW-1:0] s0;
         int n;
         f0 = 15'h7FF0 | 15'($urandom_range(0, 15));
         s0 = (it % 3 == 0) ? {SW{1'b1}} : SW'($urandom);
         n  = 6 + $urandom_range(0, 9);
         wr(A_FRAC, {17'd0, f0});
         wr(A_SECS, {8'd0, s0});
         run(n, C_FR | C_SR, 0);
         m = model(f0, s0, n);
         rd(A_FRAC, d); chk("R1 random frac", d, m[31:0]);
         rd(A_SECS, d); chk("R2 random secs", d, m[63:32]);
      end
      for (int it = 0; it < 4; it++) begin
         logic [31:0] a;
         a = $urandom;
         wr(A_FALM, a & (MD | 32'h7FFF));
         rd(A_FALM, d); chk("R8 random frac alarm", d, a & (MD | 32'h7FFF));
         wr(A_SALM, a & (MD | 32'hFF_FFFF));
         rd(A_SALM, d); chk("R8 random secs alarm", d, a & (MD | 32'hFF_FFFF));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule